// File: doc/BRIEF.md
# Extension-Instruction Clock Stretch Controller

This block sits beside a processor pipeline and looks at each instruction as it enters execution. Most opcodes belong to the base instruction set and pass with no delay. A fixed slice of the opcode space is set aside for custom instructions that run in slower reconfigurable logic. When such an opcode arrives, the block holds the pipeline long enough for that logic to finish. It raises a stall line and drops a clock-enable line to the core for that time.

The reserved slice is split into four groups by the two low opcode bits. The reconfigurable fabric drives one 4-bit stretch value per group as a steady input, so each group can have its own hold length. The block reads that value at the moment a stretch begins. A reconfiguration of the fabric between two instructions therefore affects only later instructions, never one that is already being held.

Top module: `stretch_ctrl`

## Requirements
- R1: An opcode whose upper six bits differ from 6'b111011 (that is, anything outside 8'hEC..8'hEF) never raises `stall`, even when `instr_valid` is high.
- R2: When `instr_valid` is high, `stall` is low and `opcode[7:2]` equals 6'b111011, `stall` goes high at the next clock edge.
- R3: A stretch keeps `stall` high for exactly v+1 cycles, where v is the group's 4-bit stretch value. So 4'h0 gives 1 cycle and 4'hF gives 16.
- R4: The group is `opcode[1:0]`. The value for group k is `stretch_cfg[4k+3:4k]`.
- R5: `clk_en` is always the inverse of `stall`.
- R6: Opcodes presented while `stall` is high are ignored. They neither lengthen the current stretch nor are remembered for later.
- R7: If extension instructions arrive back to back, each one gets its own full stretch. After each stretch there is one cycle with `stall` low, and the next instruction is sampled in that cycle.
- R8: The stretch value is captured when a stretch starts. A change to `stretch_cfg` during the stretch does not alter its length.
- R9: A synchronous active-high `rst` clears any stretch in progress. After reset, `stall` is low and `clk_en` is high.
- R10: With `instr_valid` low, no opcode starts a stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | An instruction is entering execution this cycle |
| opcode | input | 8 | Opcode of that instruction |
| stretch_cfg | input | 16 | Four 4-bit stretch values from the fabric, group 0 in the low nibble |
| stall | output | 1 | Registered pipeline hold |
| clk_en | output | 1 | Registered clock enable to the core, inverse of stall |

## Verification
The assertions assume three things about the inputs: `opcode` and `instr_valid` are steady around each rising edge, `stretch_cfg` is a stable level at the edge where it is sampled, and `rst` is high at the first edge. The bench meets these assumptions by changing every input only on the falling edge and by starting in reset. Inside those limits, the stimulus deliberately changes the stretch values in the middle of a hold, holds `instr_valid` high through whole stretches, and asserts reset while a hold is in progress. This exercises the cases where a careless design would re-sample its inputs.

// File: rtl/stretch_ctrl_pkg.sv
package stretch_ctrl_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } sc_state_e;
endpackage

// File: rtl/sc_opdecode.sv
module sc_opdecode #(
  parameter int OP_W  = 8,
  parameter int MAJ_W = 6,
  parameter logic [MAJ_W-1:0] EXT_MAJOR = 6'h3B,
  localparam int SET_W = OP_W - MAJ_W
) (
  input  logic             valid,
  input  logic [OP_W-1:0]  opcode,
  output logic             is_ext,
  output logic [SET_W-1:0] set_idx
);
  always_comb begin
    is_ext  = valid && (opcode[OP_W-1 -: MAJ_W] == EXT_MAJOR);
    set_idx = opcode[SET_W-1:0];
  end
endmodule

// File: rtl/sc_cfgsel.sv
module sc_cfgsel #(
  parameter int NSETS = 4,
  parameter int CNT_W = 4,
  parameter int SET_W = 2
) (
  input  logic [NSETS*CNT_W-1:0] cfg_flat,
  input  logic [SET_W-1:0]       sel,
  output logic [CNT_W-1:0]       cnt_out
);
  logic [CNT_W-1:0] cfg_arr [NSETS];

  for (genvar g = 0; g < NSETS; g++) begin : g_unpack
    assign cfg_arr[g] = cfg_flat[g*CNT_W +: CNT_W];
  end

  always_comb begin
    cnt_out = '0;
    for (int k = 0; k < NSETS; k++) begin
      if (sel == SET_W'(k)) cnt_out = cfg_arr[k];
    end
  end
endmodule

// File: rtl/sc_stretch_cnt.sv
module sc_stretch_cnt
  import stretch_ctrl_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             stall_q,
  output logic             clken_q,
  output logic [CNT_W-1:0] cnt
);
  sc_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RUN;
      cnt     <= '0;
      stall_q <= 1'b0;
      clken_q <= 1'b1;
    end else begin
      case (state)
        ST_RUN: begin
          if (start) begin
            state   <= ST_HOLD;
            cnt     <= load_val;
            stall_q <= 1'b1;
            clken_q <= 1'b0;
          end
        end
        ST_HOLD: begin
          if (cnt == '0) begin
            state   <= ST_RUN;
            stall_q <= 1'b0;
            clken_q <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  // R5
  stall_clken_chk: assert property (@(posedge clk) disable iff (rst)
    stall_q != clken_q);

  // R3
  hold_countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_q && cnt != '0) |=> (stall_q && cnt == $past(cnt) - CNT_W'(1)));

  // R3
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_q && cnt == '0) |=> !stall_q);
endmodule

// File: rtl/stretch_ctrl.sv
module stretch_ctrl #(
  parameter int OP_W  = 8,
  parameter int MAJ_W = 6,
  parameter logic [MAJ_W-1:0] EXT_MAJOR = 6'h3B,
  parameter int NSETS = 4,
  parameter int CNT_W = 4,
  localparam int SET_W = OP_W - MAJ_W,
  localparam int CFG_W = NSETS * CNT_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_valid,
  input  logic [OP_W-1:0] opcode,
  input  logic [CFG_W-1:0] stretch_cfg,
  output logic            stall,
  output logic            clk_en
);
  logic             is_ext;
  logic [SET_W-1:0] set_idx;
  logic [CNT_W-1:0] sel_cnt;
  logic [CNT_W-1:0] cnt;
  logic             start;

  sc_opdecode #(.OP_W(OP_W), .MAJ_W(MAJ_W), .EXT_MAJOR(EXT_MAJOR)) u_dec (
    .valid   (instr_valid),
    .opcode  (opcode),
    .is_ext  (is_ext),
    .set_idx (set_idx)
  );

  sc_cfgsel #(.NSETS(NSETS), .CNT_W(CNT_W), .SET_W(SET_W)) u_sel (
    .cfg_flat (stretch_cfg),
    .sel      (set_idx),
    .cnt_out  (sel_cnt)
  );

  assign start = is_ext && !stall;

  sc_stretch_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .load_val (sel_cnt),
    .stall_q  (stall),
    .clken_q  (clk_en),
    .cnt      (cnt)
  );

  // R1
  base_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && instr_valid && (opcode[OP_W-1 -: MAJ_W] != EXT_MAJOR)) |=> !stall);

  // R2
  ext_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && instr_valid && (opcode[OP_W-1 -: MAJ_W] == EXT_MAJOR)) |=> stall);

  // R8
  cfg_capture_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt == $past(stretch_cfg[opcode[SET_W-1:0]*CNT_W +: CNT_W])));

  // R10
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !instr_valid) |=> !stall);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!stall && clk_en));
endmodule

// File: tb/stretch_ctrl_tb.sv
module stretch_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] stretch_cfg = 16'h0000;
  logic        stall;
  logic        clk_en;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R9";
  bit    m_stall = 1'b0;
  int    m_rem   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stretch_ctrl u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .opcode(opcode),
    .stretch_cfg(stretch_cfg), .stall(stall), .clk_en(clk_en)
  );

  function automatic bit is_ext_op(input logic [7:0] op);
    return op[7:2] == 6'b111011;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference
  always @(posedge clk) begin
    if (rst) begin
      m_stall = 1'b0;
      m_rem   = 0;
    end else if (m_stall) begin
      if (m_rem == 0) m_stall = 1'b0;
      else m_rem = m_rem - 1;
    end else if (instr_valid && is_ext_op(opcode)) begin
      m_rem   = int'(stretch_cfg[4*opcode[1:0] +: 4]);
      m_stall = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(stall == m_stall, cur_req, "stall vs model", int'(stall), int'(m_stall));
      check(clk_en == !m_stall, "R5", "clk_en vs model", int'(clk_en), int'(!m_stall));
    end
  end

  task automatic drive(input logic v, input logic [7:0] op);
    @(negedge clk);
    instr_valid = v;
    opcode = op;
  endtask

  task automatic measure(input logic [7:0] op, input int exp_len, input string req);
    int n = 0;
    drive(1'b1, op);
    drive(1'b0, 8'h00);
    while (stall) begin
      n++;
      @(negedge clk);
    end
    check(n == exp_len, req, "stretch length", n, exp_len);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(stall == 1'b0 && clk_en == 1'b1, "R9", "reset state", int'(stall), 0);

    // R1 base opcodes, valid held
    cur_req = "R1";
    drive(1'b1, 8'hEB);
    drive(1'b1, 8'hF0);
    drive(1'b1, 8'h00);
    drive(1'b1, 8'hFF);
    for (int i = 0; i < 40; i++) begin
      logic [7:0] op = 8'($urandom);
      if (is_ext_op(op)) op = 8'h13;
      drive(1'b1, op);
    end
    drive(1'b0, 8'h00);
    @(negedge clk);
    check(stall == 1'b0, "R1", "no stall after base stream", int'(stall), 0);

    // R10 extension opcode without valid
    cur_req = "R10";
    for (int i = 0; i < 8; i++) drive(1'b0, 8'hEC + 8'(i % 4));
    @(negedge clk);
    check(stall == 1'b0, "R10", "invalid ext ignored", int'(stall), 0);

    // R3 / R4 lengths per group
    cur_req = "R4";
    stretch_cfg = {4'hF, 4'h7, 4'h3, 4'h0};
    measure(8'hEC, 1,  "R3");
    measure(8'hED, 4,  "R4");
    measure(8'hEE, 8,  "R4");
    measure(8'hEF, 16, "R3");

    // R6 opcodes during stall ignored
    cur_req = "R6";
    stretch_cfg = {4'h0, 4'h0, 4'h0, 4'h5};
    begin
      int n = 0;
      drive(1'b1, 8'hEC);
      drive(1'b1, 8'hEF);
      while (stall) begin
        n++;
        @(negedge clk);
        if (stall) begin
          instr_valid = 1'b1;
          opcode = 8'hEF;
        end else begin
          instr_valid = 1'b0;
        end
      end
      check(n == 6, "R6", "length with ops during stall", n, 6);
      drive(1'b0, 8'h00);
      @(negedge clk);
      check(stall == 1'b0, "R6", "no queued stretch", int'(stall), 0);
    end

    // R7 back to back
    cur_req = "R7";
    stretch_cfg = {4'h0, 4'h0, 4'h0, 4'h2};
    begin
      int hi = 0;
      drive(1'b1, 8'hEC);
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        if (stall) hi++;
      end
      check(hi == 12, "R7", "stall cycles in 16", hi, 12);
      instr_valid = 1'b0;
      repeat (5) @(negedge clk);
    end

    // R8 cfg change mid-stretch
    cur_req = "R8";
    stretch_cfg = {4'h0, 4'h0, 4'h0, 4'h9};
    begin
      int n = 0;
      drive(1'b1, 8'hEC);
      drive(1'b0, 8'h00);
      while (stall) begin
        n++;
        if (n == 2) stretch_cfg = 16'h0000;
        @(negedge clk);
      end
      check(n == 10, "R8", "length uses captured value", n, 10);
    end
    measure(8'hEC, 1, "R8");

    // R2 random mix with cfg changes
    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      logic [7:0] op = ($urandom % 3 == 0) ? (8'hEC + 8'($urandom % 4)) : 8'($urandom);
      if (i % 37 == 0) stretch_cfg = 16'($urandom);
      drive(1'($urandom % 4 != 0), op);
    end
    drive(1'b0, 8'h00);
    repeat (20) @(negedge clk);

    // R9 reset mid-stretch
    cur_req = "R9";
    stretch_cfg = 16'hFFFF;
    drive(1'b1, 8'hEE);
    drive(1'b0, 8'h00);
    repeat (3) @(negedge clk);
    check(stall == 1'b1, "R9", "stretch running before reset", int'(stall), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(stall == 1'b0 && clk_en == 1'b1, "R9", "cleared by reset", int'(stall), 0);
    repeat (3) @(negedge clk);
    check(stall == 1'b0, "R9", "stays idle after reset", int'(stall), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule